// File: doc/BRIEF.md
# Split-Tagged Dual-Half Instruction Buffer

This block is the per-warp staging buffer that sits between instruction decode and issue. Its four slots form two halves of two slots each, so that two divergent thread groups (splits) of the same warp can each have instructions waiting at once. Every half carries a tag made of a split identifier and a thread mask. Every filled slot also keeps a copy of the split identifier and mask that arrived with its instructions.

A decoder delivers up to two consecutive instruction words to one half per cycle. Slot 2h receives the first word and slot 2h+1 the second. Issue logic reads the slots, and can free one slot by index, pop the slot under a sequential pointer, or flush a whole half. A half can be bound to a split before any instructions arrive. A saturating counter tracks how many instructions of the warp are in flight: accepted fills add to it and retirements subtract from it.

Each half runs a small controller with three states. H_FREE means unbound and empty. H_BOUND means tagged but holding no valid slot. H_HOLD means at least one slot is valid. The transitions are:
- FREE to BOUND on an assign.
- FREE or BOUND to HOLD on an accepted fill.
- HOLD to BOUND when the last valid slot is cleared.
- Any state to FREE on a flush.

Top module: `ibuf_split_dual`

## Requirements
- R1: After reset all four slots are invalid, both halves are unbound and empty with a zero tag, the pop pointer is 0 and the in-flight count is 0.
- R2: A fill of half h with the first word valid writes that word to slot 2h. It writes the second word to slot 2h+1 only when the second word is also valid. A fill whose first word is invalid changes nothing.
- R3: Each slot written by a fill reports the fill's split id and mask. The half becomes bound, and its tag takes the same split id and mask.
- R4: An assign to a half holding no valid slot binds it and loads its tag. An assign to a half that holds a valid slot is ignored.
- R5: Half-empty status is reported separately for half 0 (bit 0) and half 1 (bit 1). A fill of one half leaves the other half's slots and status unchanged.
- R6: A free clears only the addressed slot and leaves the pop pointer unchanged. A pop clears the slot under the pointer and advances the pointer by one, wrapping from 3 to 0.
- R7: A flush of a half clears its valid bits, its bound flag and its tag on the next edge. A flush wins over a fill or an assign to the same half in the same cycle, and such a fill adds nothing to the count.
- R8: A fill to a half that still holds any valid slot is ignored: its slots are unchanged and the count does not grow.
- R9: The in-flight count rises by the number of words an accepted fill writes (1 or 2). A retire lowers it by one, and both may happen in the same cycle. A retire with a zero total is ignored, and the count saturates at its all-ones maximum.
- R10: When the last valid slot of a half is freed or popped, the half stays bound and keeps its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en_i | input | 1 | Fill strobe |
| fill_half_i | input | 1 | Half targeted by the fill |
| fill_ins0_i | input | IW | First instruction word |
| fill_v0_i | input | 1 | First word valid |
| fill_ins1_i | input | IW | Second instruction word |
| fill_v1_i | input | 1 | Second word valid |
| fill_sid_i | input | SW | Split id of the fill |
| fill_mask_i | input | MW | Thread mask of the fill |
| assign_en_i | input | 1 | Assign strobe |
| assign_half_i | input | 1 | Half targeted by the assign |
| assign_sid_i | input | SW | Split id to bind |
| assign_mask_i | input | MW | Thread mask to bind |
| flush_i | input | 2 | Per-half flush, bit h flushes half h |
| free_en_i | input | 1 | Free one slot by index |
| free_slot_i | input | 2 | Slot index to free |
| pop_i | input | 1 | Clear slot under pointer and advance it |
| retire_i | input | 1 | One in-flight instruction retired |
| slot_vld_o | output | 4 | Per-slot valid |
| slot_instr_o | output | 4*IW | Slot words, slot s at bits [s*IW +: IW] |
| slot_sid_o | output | 4*SW | Per-slot split id |
| slot_mask_o | output | 4*MW | Per-slot thread mask |
| half_empty_o | output | 2 | Per-half empty |
| half_bound_o | output | 2 | Per-half bound (assigned) flag |
| half_tag_sid_o | output | 2*SW | Per-half tag split id |
| half_tag_mask_o | output | 2*MW | Per-half tag mask |
| next_ptr_o | output | 2 | Sequential pop pointer |
| inflight_o | output | CW | In-flight instruction count |

## Verification
The bench targets these corner cases:
- Flush and fill to one half in the same cycle. A design with the wrong priority would leave stale instructions behind and inflate the count.
- A second fill to a half that is still occupied. A design that accepts it would overwrite instructions that have not yet issued.
- Freeing the last slot of a half. A design that drops the binding there would lose the split tag that the next fill is checked against.
- A retire in the same cycle as a fill, a retire with a zero count, and repeated fills past the maximum. Any of these would wrap the counter in a careless design.
- Assigns to a half that is occupied, pops through the pointer wrap, and fills that leave the other half untouched.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
    typedef enum logic [1:0] {
        H_FREE  = 2'd0,
        H_BOUND = 2'd1,
        H_HOLD  = 2'd2
    } half_state_e;

    localparam int unsigned NUM_HALVES     = 2;
    localparam int unsigned SLOTS_PER_HALF = 2;
endpackage

// File: rtl/ibuf_half.sv
module ibuf_half
    import ibuf_pkg::*;
#(
    parameter int unsigned IW = 32,
    parameter int unsigned SW = 4,
    parameter int unsigned MW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   fill_i,
    input  logic [IW-1:0]          ins0_i,
    input  logic                   ins0_v_i,
    input  logic [IW-1:0]          ins1_i,
    input  logic                   ins1_v_i,
    input  logic [SW-1:0]          sid_i,
    input  logic [MW-1:0]          mask_i,
    input  logic                   assign_i,
    input  logic [SW-1:0]          asid_i,
    input  logic [MW-1:0]          amask_i,
    input  logic [1:0]             clr_i,
    output logic [1:0]             vld_o,
    output logic [1:0][IW-1:0]     instr_o,
    output logic [1:0][SW-1:0]     sid_o,
    output logic [1:0][MW-1:0]     smask_o,
    output logic                   bound_o,
    output logic [SW-1:0]          tsid_o,
    output logic [MW-1:0]          tmask_o,
    output logic                   empty_o,
    output logic [1:0]             acc_cnt_o
);
    half_state_e           state_q, state_d;
    logic [1:0]            vld_q, vld_d;
    logic [1:0][IW-1:0]    instr_q;
    logic [1:0][SW-1:0]    sid_q;
    logic [1:0][MW-1:0]    smask_q;
    logic [SW-1:0]         tsid_q;
    logic [MW-1:0]         tmask_q;
    logic                  empty, accept, take1, assign_ok;

    assign empty     = (vld_q == 2'b00);
    assign accept    = fill_i & ins0_v_i & empty & ~flush_i;
    assign take1     = accept & ins1_v_i;
    assign assign_ok = assign_i & ~flush_i & ~accept & empty;

    always_comb begin
        vld_d[0] = flush_i ? 1'b0 : accept ? 1'b1     : clr_i[0] ? 1'b0 : vld_q[0];
        vld_d[1] = flush_i ? 1'b0 : accept ? ins1_v_i : clr_i[1] ? 1'b0 : vld_q[1];
    end

    // next-state logic of the half controller
    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = H_FREE;
        end else begin
            unique case (state_q)
                H_FREE:  if (accept) state_d = H_HOLD;
                         else if (assign_ok) state_d = H_BOUND;
                H_BOUND: if (accept) state_d = H_HOLD;
                H_HOLD:  if (vld_d == 2'b00) state_d = H_BOUND;
                default: state_d = H_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= H_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            instr_q <= '0;
            sid_q   <= '0;
            smask_q <= '0;
            tsid_q  <= '0;
            tmask_q <= '0;
        end else begin
            vld_q <= vld_d;
            if (accept) begin
                instr_q[0] <= ins0_i;
                sid_q[0]   <= sid_i;
                smask_q[0] <= mask_i;
            end
            if (take1) begin
                instr_q[1] <= ins1_i;
                sid_q[1]   <= sid_i;
                smask_q[1] <= mask_i;
            end
            if (flush_i) begin
                tsid_q  <= '0;
                tmask_q <= '0;
            end else if (accept) begin
                tsid_q  <= sid_i;
                tmask_q <= mask_i;
            end else if (assign_ok) begin
                tsid_q  <= asid_i;
                tmask_q <= amask_i;
            end
        end
    end

    // outputs
    always_comb begin
        vld_o     = vld_q;
        instr_o   = instr_q;
        sid_o     = sid_q;
        smask_o   = smask_q;
        bound_o   = (state_q != H_FREE);
        tsid_o    = tsid_q;
        tmask_o   = tmask_q;
        empty_o   = empty;
        acc_cnt_o = accept ? (take1 ? 2'd2 : 2'd1) : 2'd0;
    end

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_o == 2'b00 && !bound_o && tmask_o == '0 && tsid_o == '0));

    assert_hold_has_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == H_HOLD) |-> (vld_q != 2'b00));

    assert_busy_fill_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !empty && !flush_i) |=> $stable(instr_o));

    assert_slot_tag_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (sid_o[0] == tsid_o && smask_o[0] == tmask_o && bound_o));

    assert_last_free_keeps_bind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == H_HOLD && !flush_i && !accept && vld_d == 2'b00) |=> bound_o);
endmodule

// File: rtl/ibuf_inflight_ctr.sv
module ibuf_inflight_ctr #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW+1:0] MAXV = {2'b00, {CW{1'b1}}};

    logic [CW-1:0] cnt_q;
    logic [CW+1:0] sum;

    always_comb begin
        sum = {2'b00, cnt_q} + {{CW{1'b0}}, inc_i};
        if (dec_i && sum != '0) sum = sum - 1'b1;
        if (sum > MAXV) sum = MAXV;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= sum[CW-1:0];
    end

    assign cnt_o = cnt_q;

    assert_ctr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i == 2'd0 && !dec_i) |=> $stable(cnt_o));

    assert_ctr_zero_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && inc_i == 2'd0) |=> (cnt_o == '0));
endmodule

// File: rtl/ibuf_split_dual.sv
module ibuf_split_dual
    import ibuf_pkg::*;
#(
    parameter int unsigned IW = 32,
    parameter int unsigned SW = 4,
    parameter int unsigned MW = 32,
    parameter int unsigned CW = 6
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      fill_en_i,
    input  logic [$clog2(NUM_HALVES)-1:0]             fill_half_i,
    input  logic [IW-1:0]                             fill_ins0_i,
    input  logic                                      fill_v0_i,
    input  logic [IW-1:0]                             fill_ins1_i,
    input  logic                                      fill_v1_i,
    input  logic [SW-1:0]                             fill_sid_i,
    input  logic [MW-1:0]                             fill_mask_i,
    input  logic                                      assign_en_i,
    input  logic [$clog2(NUM_HALVES)-1:0]             assign_half_i,
    input  logic [SW-1:0]                             assign_sid_i,
    input  logic [MW-1:0]                             assign_mask_i,
    input  logic [NUM_HALVES-1:0]                     flush_i,
    input  logic                                      free_en_i,
    input  logic [$clog2(NUM_HALVES*SLOTS_PER_HALF)-1:0] free_slot_i,
    input  logic                                      pop_i,
    input  logic                                      retire_i,
    output logic [NUM_HALVES*SLOTS_PER_HALF-1:0]      slot_vld_o,
    output logic [NUM_HALVES*SLOTS_PER_HALF*IW-1:0]   slot_instr_o,
    output logic [NUM_HALVES*SLOTS_PER_HALF*SW-1:0]   slot_sid_o,
    output logic [NUM_HALVES*SLOTS_PER_HALF*MW-1:0]   slot_mask_o,
    output logic [NUM_HALVES-1:0]                     half_empty_o,
    output logic [NUM_HALVES-1:0]                     half_bound_o,
    output logic [NUM_HALVES*SW-1:0]                  half_tag_sid_o,
    output logic [NUM_HALVES*MW-1:0]                  half_tag_mask_o,
    output logic [$clog2(NUM_HALVES*SLOTS_PER_HALF)-1:0] next_ptr_o,
    output logic [CW-1:0]                             inflight_o
);
    localparam int unsigned NH  = NUM_HALVES;
    localparam int unsigned SPH = SLOTS_PER_HALF;
    localparam int unsigned NS  = NH * SPH;
    localparam int unsigned PW  = $clog2(NS);
    localparam int unsigned HW  = $clog2(NH);

    logic [PW-1:0]       ptr_q;
    logic [NH-1:0][1:0]  acc_cnt;
    logic [1:0]          inc_all;

    genvar h, k;
    generate
        for (h = 0; h < NH; h++) begin : g_half
            logic [SPH-1:0]         clr;
            logic [1:0][IW-1:0]     instr;
            logic [1:0][SW-1:0]     sid;
            logic [1:0][MW-1:0]     smask;
            logic [1:0]             vld;

            for (k = 0; k < SPH; k++) begin : g_slot
                assign clr[k] = (free_en_i && free_slot_i == PW'(h*SPH + k)) ||
                                (pop_i && ptr_q == PW'(h*SPH + k));
                assign slot_vld_o[h*SPH + k]                 = vld[k];
                assign slot_instr_o[(h*SPH + k)*IW +: IW]    = instr[k];
                assign slot_sid_o[(h*SPH + k)*SW +: SW]      = sid[k];
                assign slot_mask_o[(h*SPH + k)*MW +: MW]     = smask[k];
            end

            ibuf_half #(.IW(IW), .SW(SW), .MW(MW)) u_half (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush_i   (flush_i[h]),
                .fill_i    (fill_en_i && fill_half_i == HW'(h)),
                .ins0_i    (fill_ins0_i),
                .ins0_v_i  (fill_v0_i),
                .ins1_i    (fill_ins1_i),
                .ins1_v_i  (fill_v1_i),
                .sid_i     (fill_sid_i),
                .mask_i    (fill_mask_i),
                .assign_i  (assign_en_i && assign_half_i == HW'(h)),
                .asid_i    (assign_sid_i),
                .amask_i   (assign_mask_i),
                .clr_i     (clr),
                .vld_o     (vld),
                .instr_o   (instr),
                .sid_o     (sid),
                .smask_o   (smask),
                .bound_o   (half_bound_o[h]),
                .tsid_o    (half_tag_sid_o[h*SW +: SW]),
                .tmask_o   (half_tag_mask_o[h*MW +: MW]),
                .empty_o   (half_empty_o[h]),
                .acc_cnt_o (acc_cnt[h])
            );
        end
    endgenerate

    // only one half is addressed by a fill, so the counts merge by OR
    always_comb begin
        inc_all = 2'd0;
        for (int i = 0; i < NH; i++) inc_all = inc_all | acc_cnt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (pop_i) ptr_q <= ptr_q + 1'b1;
    end

    assign next_ptr_o = ptr_q;

    ibuf_inflight_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc_all),
        .dec_i (retire_i),
        .cnt_o (inflight_o)
    );

    assert_free_clears_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en_i && !fill_en_i) |=> !slot_vld_o[$past(free_slot_i)]);

    assert_free_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en_i && !pop_i) |=> (next_ptr_o == $past(next_ptr_o)));

    assert_one_fill_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en_i |-> (inc_all == 2'd0));
endmodule

// File: tb/sim_ibuf_split_dual.sv
`timescale 1ns/1ps
module sim_ibuf_split_dual;
    localparam int IW = 16, SW = 3, MW = 8, CW = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic fill_en, fill_half, fill_v0, fill_v1, assign_en, assign_half;
    logic [IW-1:0] fill_ins0, fill_ins1;
    logic [SW-1:0] fill_sid, assign_sid;
    logic [MW-1:0] fill_mask, assign_mask;
    logic [1:0] flush;
    logic free_en, pop, retire;
    logic [1:0] free_slot;
    logic [3:0] slot_vld;
    logic [4*IW-1:0] slot_instr;
    logic [4*SW-1:0] slot_sid;
    logic [4*MW-1:0] slot_mask;
    logic [1:0] half_empty, half_bound;
    logic [2*SW-1:0] tag_sid;
    logic [2*MW-1:0] tag_mask;
    logic [1:0] next_ptr;
    logic [CW-1:0] inflight;

    ibuf_split_dual #(.IW(IW), .SW(SW), .MW(MW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_en_i(fill_en), .fill_half_i(fill_half), .fill_ins0_i(fill_ins0),
        .fill_v0_i(fill_v0), .fill_ins1_i(fill_ins1), .fill_v1_i(fill_v1),
        .fill_sid_i(fill_sid), .fill_mask_i(fill_mask),
        .assign_en_i(assign_en), .assign_half_i(assign_half),
        .assign_sid_i(assign_sid), .assign_mask_i(assign_mask),
        .flush_i(flush), .free_en_i(free_en), .free_slot_i(free_slot),
        .pop_i(pop), .retire_i(retire),
        .slot_vld_o(slot_vld), .slot_instr_o(slot_instr), .slot_sid_o(slot_sid),
        .slot_mask_o(slot_mask), .half_empty_o(half_empty), .half_bound_o(half_bound),
        .half_tag_sid_o(tag_sid), .half_tag_mask_o(tag_mask),
        .next_ptr_o(next_ptr), .inflight_o(inflight)
    );

    int total = 0, fails = 0, exp_cnt = 0;
    bit done = 1'b0;

    // vector: {half, v0, v1, sid[2:0], mask[7:0], ins0[15:0], ins1[15:0]}
    localparam logic [45:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b1, 3'd2, 8'hA5, 16'h1111, 16'h2222},
        {1'b1, 1'b1, 1'b0, 3'd4, 8'h0F, 16'h3333, 16'h4444},
        {1'b0, 1'b0, 1'b1, 3'd6, 8'hF0, 16'h5555, 16'h6666},
        {1'b1, 1'b1, 1'b1, 3'd7, 8'h81, 16'h7777, 16'h8888},
        {1'b0, 1'b1, 1'b0, 3'd1, 8'h3C, 16'h9999, 16'hAAAA},
        {1'b1, 1'b0, 1'b0, 3'd3, 8'hC3, 16'hBBBB, 16'hCCCC}
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int cnt_next(input int c, input int inc, input bit dec);
        int s = c + inc;
        if (dec && s > 0) s--;
        if (s > CMAX) s = CMAX;
        return s;
    endfunction

    task automatic idle();
        fill_en = 0; fill_half = 0; fill_v0 = 0; fill_v1 = 0;
        fill_ins0 = '0; fill_ins1 = '0; fill_sid = '0; fill_mask = '0;
        assign_en = 0; assign_half = 0; assign_sid = '0; assign_mask = '0;
        flush = 2'b00; free_en = 0; free_slot = '0; pop = 0; retire = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic do_fill(input logic h, input logic v0, input logic v1,
                           input logic [SW-1:0] s, input logic [MW-1:0] m,
                           input logic [IW-1:0] a, input logic [IW-1:0] b);
        fill_en = 1; fill_half = h; fill_v0 = v0; fill_v1 = v1;
        fill_sid = s; fill_mask = m; fill_ins0 = a; fill_ins1 = b;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 slot_vld", slot_vld, 4'h0);
        chk("R1 bound", half_bound, 2'b00);
        chk("R1 empty", half_empty, 2'b11);
        chk("R1 tag", {tag_sid, tag_mask}, '0);
        chk("R1 ptr", next_ptr, 2'd0);
        chk("R1 count", inflight, 0);

        // table-driven fills, each into a freshly flushed buffer
        for (int i = 0; i < 6; i++) begin
            logic [45:0] v;
            int h, b, inc;
            v = VEC[i];
            flush = 2'b11; step();
            do_fill(v[45], v[44], v[43], v[42:40], v[39:32], v[31:16], v[15:0]);
            step();
            h = int'(v[45]); b = 2*h;
            inc = int'(v[44]) + int'(v[44] & v[43]);
            exp_cnt = cnt_next(exp_cnt, inc, 1'b0);
            chk("R2 slot base vld", slot_vld[b], v[44]);
            chk("R2 slot base+1 vld", slot_vld[b+1], v[44] & v[43]);
            chk("R5 other half untouched", slot_vld[2*(1-h) +: 2], 2'b00);
            if (v[44]) begin
                chk("R2 base word", slot_instr[b*IW +: IW], v[31:16]);
                chk("R3 slot sid", slot_sid[b*SW +: SW], v[42:40]);
                chk("R3 slot mask", slot_mask[b*MW +: MW], v[39:32]);
            end
            if (v[44] & v[43]) chk("R2 second word", slot_instr[(b+1)*IW +: IW], v[15:0]);
            chk("R3 half bound", half_bound[h], v[44]);
            chk("R3 tag sid", tag_sid[h*SW +: SW], v[44] ? v[42:40] : 3'd0);
            chk("R3 tag mask", tag_mask[h*MW +: MW], v[44] ? v[39:32] : 8'd0);
            chk("R9 count after fill", inflight, exp_cnt);
        end

        flush = 2'b11; step();
        while (exp_cnt > 0) begin
            retire = 1; step(); exp_cnt--;
        end
        retire = 1; step();
        chk("R9 retire at zero", inflight, 0);

        do_fill(0, 1, 1, 3'd5, 8'h3C, 16'hA0A0, 16'hB0B0); step();
        exp_cnt = 2;
        chk("R9 two words", inflight, exp_cnt);
        do_fill(0, 1, 1, 3'd1, 8'h11, 16'hC0C0, 16'hD0D0); step();
        chk("R8 busy fill word", slot_instr[0 +: IW], 16'hA0A0);
        chk("R8 busy fill count", inflight, exp_cnt);

        free_en = 1; free_slot = 2'd1; step();
        chk("R6 free slot vld", slot_vld[1:0], 2'b01);
        chk("R6 free ptr", next_ptr, 2'd0);

        pop = 1; step();
        chk("R6 pop clears", slot_vld[0], 1'b0);
        chk("R6 pop ptr", next_ptr, 2'd1);
        chk("R10 still bound", half_bound[0], 1'b1);
        chk("R10 tag kept", tag_sid[0 +: SW], 3'd5);
        chk("R5 half0 empty", half_empty, 2'b11);

        assign_en = 1; assign_half = 0; assign_sid = 3'd2; assign_mask = 8'h81; step();
        chk("R4 rebind empty half", {tag_sid[0 +: SW], tag_mask[0 +: MW]}, {3'd2, 8'h81});
        assign_en = 1; assign_half = 1; assign_sid = 3'd3; assign_mask = 8'h0F; step();
        chk("R4 bind free half", {half_bound[1], tag_sid[SW +: SW]}, {1'b1, 3'd3});

        do_fill(1, 1, 0, 3'd6, 8'hF0, 16'hE0E0, 16'hF0F0); retire = 1; step();
        exp_cnt = cnt_next(exp_cnt, 1, 1'b1);
        chk("R2 single word", slot_vld[3:2], 2'b01);
        chk("R5 empty per half", half_empty, 2'b01);
        chk("R9 fill plus retire", inflight, exp_cnt);

        assign_en = 1; assign_half = 1; assign_sid = 3'd7; assign_mask = 8'hFF; step();
        chk("R4 assign ignored while held", tag_sid[SW +: SW], 3'd6);

        flush = 2'b10; do_fill(1, 1, 1, 3'd4, 8'h55, 16'h1234, 16'h5678); step();
        chk("R7 flush beats fill vld", slot_vld[3:2], 2'b00);
        chk("R7 unbound", half_bound, 2'b01);
        chk("R7 tag cleared", tag_mask[MW +: MW], 8'h00);
        chk("R7 no count", inflight, exp_cnt);

        for (int i = 0; i < 4; i++) begin
            do_fill(1, 1, 1, 3'd1, 8'h01, 16'h0001, 16'h0002); step();
            exp_cnt = cnt_next(exp_cnt, 2, 1'b0);
            chk("R9 count saturating", inflight, exp_cnt);
            flush = 2'b10; step();
        end
        chk("R9 saturated max", inflight, CMAX);

        pop = 1; step(); pop = 1; step(); pop = 1; step();
        chk("R6 pointer wraps", next_ptr, 2'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule